// File: doc/BRIEF.md
# Register-Driven I2C Bus Master

This block is an I2C bus master that software steps through one event at a time using a small word-addressed register file. Software loads a target byte (7-bit device address in bits 7:1, direction in bit 0) and sets the start bits in the control word. The controller then emits a start condition and shifts that byte out most significant bit first. After that it stops with SCL held low and waits. It resumes only when software clears the event flag it raised.

In a write, software places one byte in the data register while the data-empty flag is up, then clears that flag to send the byte. In a read, clearing the data-received flag clocks in the next byte. Setting the force-stop bit before the last read byte is released makes the controller NAK that byte and then finish with a stop. Setting force-stop while a write is parked sends a stop straight away, and the same applies after a NAK. Two other paths bypass the state machine: a pin-override mode lets software set each line directly, and writing a control word whose enable bit is 0 abandons the transfer at once.

Pins are open-drain. An output-enable of 1 pulls the line low and 0 releases it. Each line also has an input. One SCL bit lasts four phases, and each phase lasts clock-configuration + 1 clock cycles.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset the control, status, interrupt-enable, target and data registers read 0, the clock configuration reads the CFG_RST parameter (default 49), both lines are released and `irq` is 0.
- R2: Writing control with bit 7 (enable), bit 3 (interface enable) and bit 0 (start) set, while the controller is idle, produces a start (SDA falls while SCL is high) followed by the target register byte, MSB first. Bit 0 of control clears itself when the start is taken. During a byte, SDA changes only while SCL is low.
- R3: At the end of the address byte, status bit 0 (address sent) is set. Status bit 1 (data received) is also set if target bit 0 is 1, otherwise status bit 3 (data empty) is set. Status bit 6 (NAK) is set if SDA was high in the acknowledge slot.
- R4: A write to the data register (offset 0x24) loads the transmit byte only while status bit 3 is 1. In a write, clearing bit 3 after such a load sends that byte, and bits 2 (byte sent) and 3 are then set.
- R5: In a read, clearing status bit 1 clocks in one byte with an ACK (SDA driven low in the acknowledge slot) and sets bit 1 again. The data register then returns that byte in bits 7:0, with bits 31:8 reading 0.
- R6: If control bit 1 (force stop) is set when a read byte is released, that byte gets a NAK (SDA released) and a stop follows without waiting. Status bit 4 (stop sent) is set when the stop completes.
- R7: While a write is parked, or after a NAK, setting control bit 1 sends a stop (SDA rises while SCL is high) and sets status bit 4. Bit 4 becomes 1 only as the controller returns to idle.
- R8: A write to status (offset 0x0C) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R9: With control bit 4 (override) set, `scl_oe` equals the inverse of control bit 6 and `sda_oe` equals the inverse of control bit 5.
- R10: Writing control with bit 7 = 0 returns the controller to idle and releases both lines by the next clock cycle. No stop is sent and status bit 4 stays 0.
- R11: If the master releases SDA for a 1 in a transmitted bit but samples SDA low, it sets status bit 5 (arbitration lost), releases both lines and goes idle without a stop.
- R12: `irq` is 1 exactly when control bit 3 is 1 and some status bit is 1 whose interrupt-enable bit (offset 0x14) is also 1.
- R13: A bit does not proceed past its SCL-high phase while the sampled SCL line is held low by another device. It resumes once SCL is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |
| scl_i | input | 1 | SCL pad input |
| scl_oe | output | 1 | SCL pad pull-low enable |
| sda_i | input | 1 | SDA pad input |
| sda_oe | output | 1 | SDA pad pull-low enable |

## Verification
The assertions assume that software keeps to the handshake. The data register is written only while the controller is parked, status writes never try to set bits, and the pad inputs are the wired-AND of this master with the other devices on the bus. The bench enforces these assumptions. Its target model drives SDA only while SCL is low and releases the line after a NAK. Its simulated second master pulls SDA low only for the arbitration scenario. Every register access is made at a falling clock edge, after polling the status flags the handshake names.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter logic [31:0] CFG_RST = 32'd49
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        scl_i,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe
);
  localparam logic [5:0] A_CTRL = 6'h04, A_STAT = 6'h0C, A_IEN = 6'h14,
                         A_CCFG = 6'h18, A_TAR = 6'h20, A_DATA = 6'h24;
  localparam int C_MEN = 7, C_FSCL = 6, C_FSDA = 5, C_OVR = 4, C_MIE = 3, C_FSB = 1, C_ESG = 0;
  localparam int S_NAK = 6, S_ARB = 5, S_STP = 4, S_EMP = 3, S_TXD = 2, S_RXD = 1, S_ADR = 0;

  typedef enum logic [2:0] {IDLE, START, BITS, HOLD, STOP} state_t;

  state_t      state;
  logic [1:0]  ph;
  logic [31:0] cnt, ccfg;
  logic [7:0]  ctrl, tar, sh, rx;
  logic [6:0]  st, ien;
  logic [3:0]  bitn;
  logic        rd_mode, addr_ph, loaded, nak_cur, ack_nak;
  logic        scl_low, sda_low;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_stat  = bus_wr && bus_addr == A_STAT;
  wire wr_data  = bus_wr && bus_addr == A_DATA;
  wire txing    = addr_ph || !rd_mode;
  wire abort    = (wr_ctrl && !bus_wdata[C_MEN]) || !ctrl[C_MEN];
  wire stretch  = state == BITS && ph == 2'd1 && !scl_i;
  wire tick     = cnt == ccfg && !stretch;
  wire go       = ctrl[C_MEN] && ctrl[C_MIE] && ctrl[C_ESG];

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (state)
      START: begin scl_low = ph == 2'd3; sda_low = ph[1]; end
      BITS: begin
        scl_low = ph == 2'd0 || ph == 2'd3;
        sda_low = (bitn != 4'd0) ? (txing && !sh[7]) : (!txing && !nak_cur);
      end
      HOLD: scl_low = 1'b1;
      STOP: begin scl_low = ph == 2'd0; sda_low = !ph[1]; end
      default: ;
    endcase
  end

  assign scl_oe = ctrl[C_OVR] ? !ctrl[C_FSCL] : scl_low;
  assign sda_oe = ctrl[C_OVR] ? !ctrl[C_FSDA] : sda_low;
  assign irq    = ctrl[C_MIE] && |(st & ien);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'd0, ctrl};
      A_STAT:  bus_rdata = {25'd0, st};
      A_IEN:   bus_rdata = {25'd0, ien};
      A_CCFG:  bus_rdata = ccfg;
      A_TAR:   bus_rdata = {24'd0, tar};
      A_DATA:  bus_rdata = {24'd0, rx};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; ph <= '0; cnt <= '0; ccfg <= CFG_RST;
      ctrl <= '0; tar <= '0; sh <= '0; rx <= '0; st <= '0; ien <= '0;
      bitn <= '0; rd_mode <= 1'b0; addr_ph <= 1'b0; loaded <= 1'b0;
      nak_cur <= 1'b0; ack_nak <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_IEN) ien <= bus_wdata[6:0];
      if (bus_wr && bus_addr == A_CCFG) ccfg <= bus_wdata;
      if (bus_wr && bus_addr == A_TAR) tar <= bus_wdata[7:0];
      if (wr_stat) st <= st & bus_wdata[6:0];
      if (wr_data && st[S_EMP]) begin sh <= bus_wdata[7:0]; loaded <= 1'b1; end
      cnt <= (state == IDLE || state == HOLD || tick || stretch) ? '0 : cnt + 32'd1;
      if (tick && (state == START || state == BITS || state == STOP)) ph <= ph + 2'd1;

      if (abort) begin
        state <= IDLE;
        loaded <= 1'b0;
      end else begin
        case (state)
          IDLE: if (go) begin
            state <= START; ph <= '0; cnt <= '0; sh <= tar; rd_mode <= tar[0];
            addr_ph <= 1'b1; bitn <= 4'd8; loaded <= 1'b0;
            if (!wr_ctrl) ctrl[C_ESG] <= 1'b0;
          end
          START: if (tick && ph == 2'd3) state <= BITS;
          BITS: if (tick) begin
            if (ph == 2'd2) begin
              if (bitn == 4'd0) ack_nak <= sda_i;
              else if (!txing) sh <= {sh[6:0], sda_i};
              else if (sh[7] && !sda_i) begin st[S_ARB] <= 1'b1; state <= IDLE; end
            end
            if (ph == 2'd3) begin
              if (bitn != 4'd0) begin
                bitn <= bitn - 4'd1;
                if (txing) sh <= {sh[6:0], 1'b0};
              end else if (addr_ph) begin
                st[S_ADR] <= 1'b1;
                if (rd_mode) st[S_RXD] <= 1'b1; else st[S_EMP] <= 1'b1;
                if (ack_nak) st[S_NAK] <= 1'b1;
                addr_ph <= 1'b0;
                state <= HOLD;
              end else if (!rd_mode) begin
                st[S_TXD] <= 1'b1; st[S_EMP] <= 1'b1;
                if (ack_nak) st[S_NAK] <= 1'b1;
                state <= HOLD;
              end else begin
                rx <= sh; st[S_RXD] <= 1'b1;
                state <= nak_cur ? STOP : HOLD;
              end
            end
          end
          HOLD: begin
            cnt <= '0;
            if ((!rd_mode || st[S_NAK]) && ctrl[C_FSB]) state <= STOP;
            else if (rd_mode && !st[S_RXD]) begin
              state <= BITS; bitn <= 4'd8; nak_cur <= ctrl[C_FSB];
            end else if (!rd_mode && !st[S_EMP] && loaded) begin
              state <= BITS; bitn <= 4'd8; loaded <= 1'b0;
            end
          end
          STOP: if (tick && ph == 2'd3) begin st[S_STP] <= 1'b1; state <= IDLE; end
          default: state <= IDLE;
        endcase
      end
    end
  end

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[7:0] == 8'd0) |=> (!scl_oe && !sda_oe && state == IDLE));

  p_keep_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((st & $past(st & bus_wdata[6:0])) == $past(st & bus_wdata[6:0])));

  p_data_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !st[S_EMP] && state == HOLD) |=> $stable(sh));

  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BITS && $past(state) == BITS && !ctrl[C_OVR] && !$past(ctrl[C_OVR])
     && sda_oe != $past(sda_oe)) |-> $past(scl_oe));

  p_stop_at_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[S_STP]) |-> state == IDLE);
endmodule

// File: tb/sim_i2c_reg_master.sv
module sim_i2c_reg_master;
  localparam logic [5:0] CTRL = 6'h04, STAT = 6'h0C, IEN = 6'h14, CCFG = 6'h18, TAR = 6'h20, DATA = 6'h24;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq, scl_oe, sda_oe;
  logic        slv_low = 1'b0, ext_low = 1'b0, ext_scl_low = 1'b0;
  wire         scl_line = ~scl_oe & ~ext_scl_low;
  wire         sda_line = ~sda_oe & ~slv_low & ~ext_low;

  i2c_reg_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .scl_i(scl_line),
    .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // target model
  int bc = 0, wn = 0, stops = 0;
  bit act = 0, aph = 0, isrd = 0, quiet = 0, mack = 0;
  logic [7:0] sr = '0, txb = '0, nxt = '0, adr_seen = '0;
  logic [7:0] wlog [4];

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    act = 1; bc = -1; aph = 1; quiet = 0; slv_low = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1 && act) begin
    act = 0; stops++; slv_low = 0;
  end
  always @(posedge scl_line) if (act) begin
    if (bc >= 0 && bc < 8) sr = {sr[6:0], sda_line};
    else if (bc == 8 && isrd && !aph) mack = ~sda_line;
  end
  always @(negedge scl_line) if (act) begin
    bc++;
    if (bc == 8) begin
      if (aph) begin
        adr_seen = sr; isrd = sr[0]; slv_low = (sr[7:1] == SLV);
        quiet = (sr[7:1] != SLV);
      end else if (!isrd) begin
        if (wn < 4) wlog[wn] = sr;
        wn++; slv_low = 1;
      end else slv_low = 0;
    end else if (bc == 9) begin
      bc = 0;
      if (!aph && isrd && !mack) quiet = 1;
      aph = 0;
      if (isrd && !quiet) begin txb = nxt; nxt = nxt + 8'h11; slv_low = ~txb[7]; end
      else slv_low = 0;
    end else if (bc >= 1 && bc <= 7 && isrd && !aph && !quiet) slv_low = ~txb[7 - bc];
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_st(input logic [6:0] m, input string req);
    logic [31:0] d = '0;
    for (int k = 0; k < 3000; k++) begin
      rd(STAT, d);
      if ((d[6:0] & m) == m) break;
    end
    chk(req, {25'd0, d[6:0] & m}, {25'd0, m});
  endtask

  task automatic cleanup();
    wr(CTRL, 32'h0); wr(STAT, 32'h0); ext_low = 1'b0; ext_scl_low = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(CTRL, d); chk("R1 control", d, 32'h0);
    rd(STAT, d); chk("R1 status", d, 32'h0);
    rd(CCFG, d); chk("R1 clock config", d, 32'd49);
    rd(DATA, d); chk("R1 data", d, 32'h0);
    chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    int s0 = stops;
    wn = 0;
    wr(TAR, 32'h54); wr(CTRL, 32'h89);
    wait_st(7'h01, "R3 address phase done");
    rd(STAT, d); chk("R3 write address flags", d, 32'h09);
    chk("R2 address byte seen by target", {24'd0, adr_seen}, 32'h54);
    rd(CTRL, d); chk("R2 start bit self-clears", d, 32'h88);
    wr(DATA, 32'h3C); wr(STAT, 32'h77);
    rd(STAT, d); chk("R8 zero clears, one keeps", d, 32'h01);
    wr(DATA, 32'hFF);
    wait_st(7'h0C, "R4 first byte sent");
    chk("R4 first byte, late write ignored", {24'd0, wlog[0]}, 32'h3C);
    wr(DATA, 32'hA1); wr(STAT, 32'h73);
    wait_st(7'h0C, "R4 second byte sent");
    chk("R4 second byte", {24'd0, wlog[1]}, 32'hA1);
    chk("R4 byte count", wn, 2);
    wr(STAT, 32'h77); wr(CTRL, 32'h8A);
    wait_st(7'h10, "R7 stop after write");
    chk("R7 target saw stop", stops - s0, 1);
  endtask

  task automatic t_read();
    logic [31:0] d;
    int s0 = stops;
    nxt = 8'hC3;
    wr(TAR, 32'h55); wr(CTRL, 32'h89);
    wait_st(7'h03, "R3 read address phase");
    rd(STAT, d); chk("R3 read address flags", d, 32'h03);
    wr(STAT, 32'h7D);
    wait_st(7'h02, "R5 byte received");
    rd(DATA, d); chk("R5 first read byte, upper zero", d, 32'hC3);
    chk("R5 master acked", {31'd0, mack}, 32'h1);
    wr(CTRL, 32'h8A); wr(STAT, 32'h7D);
    wait_st(7'h10, "R6 stop after last byte");
    rd(DATA, d); chk("R6 last read byte", d, 32'hD4);
    chk("R6 last byte NAKed", {31'd0, mack}, 32'h0);
    chk("R6 target saw stop", stops - s0, 1);
  endtask

  task automatic t_nak_irq();
    logic [31:0] d;
    wr(TAR, 32'h20); wr(CTRL, 32'h89);
    wait_st(7'h01, "R3 address phase (absent target)");
    rd(STAT, d); chk("R3 NAK flag", d, 32'h49);
    wr(CTRL, 32'h8A);
    wait_st(7'h10, "R7 stop after NAK");
    wr(IEN, 32'h10); chk("R12 irq on enabled flag", {31'd0, irq}, 32'h1);
    wr(IEN, 32'h00); chk("R12 irq masked", {31'd0, irq}, 32'h0);
    wr(IEN, 32'h10); wr(CTRL, 32'h80); chk("R12 irq gated by bit 3", {31'd0, irq}, 32'h0);
    wr(IEN, 32'h00);
  endtask

  task automatic t_override();
    wr(CTRL, 32'h90); chk("R9 both forced low", {30'd0, scl_oe, sda_oe}, 32'h3);
    wr(CTRL, 32'hD0); chk("R9 SCL high SDA low", {30'd0, scl_oe, sda_oe}, 32'h1);
    wr(CTRL, 32'hB0); chk("R9 SCL low SDA high", {30'd0, scl_oe, sda_oe}, 32'h2);
    wr(CTRL, 32'hF0); chk("R9 both released", {30'd0, scl_oe, sda_oe}, 32'h0);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(TAR, 32'h54); wr(CTRL, 32'h89);
    wait_st(7'h01, "R10 transfer parked");
    chk("R10 SCL held in park", {31'd0, scl_oe}, 32'h1);
    wr(CTRL, 32'h0);
    chk("R10 lines released next cycle", {30'd0, scl_oe, sda_oe}, 32'h0);
    repeat (200) @(negedge clk);
    rd(STAT, d); chk("R10 no stop after abort", d & 32'h10, 32'h0);
  endtask

  task automatic t_stretch();
    logic [31:0] d;
    wr(TAR, 32'h54); wr(CTRL, 32'h89);
    @(negedge sda_line);
    @(negedge clk); ext_scl_low = 1'b1;
    repeat (300) @(negedge clk);
    rd(STAT, d); chk("R13 held while SCL low", d, 32'h0);
    ext_scl_low = 1'b0;
    wait_st(7'h01, "R13 resumes after release");
    rd(STAT, d); chk("R13 address acked after stretch", d, 32'h09);
    wr(CTRL, 32'h8A);
    wait_st(7'h10, "R13 stop after stretch");
  endtask

  task automatic t_arb();
    logic [31:0] d;
    ext_low = 1'b1;
    wr(TAR, 32'h80); wr(CTRL, 32'h89);
    wait_st(7'h20, "R11 arbitration lost flag");
    chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
    rd(STAT, d); chk("R11 no address or stop flags", d & 32'h11, 32'h0);
    ext_low = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wr(CCFG, 32'd1);
    t_write();   cleanup();
    t_read();    cleanup();
    t_nak_irq(); cleanup();
    t_override(); cleanup();
    t_abort();   cleanup();
    t_stretch(); cleanup();
    t_arb();     cleanup();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule